// File: doc/BRIEF.md
# Half-Duplex Radio Operating Mode Controller

This block sequences the power and operating states of a half-duplex radio. It has eight states: deep sleep, idle, light sleep, standby, calibration, settling, transmit and receive. Software writes a 3-bit mode command with a strobe. The controller accepts the command only when it is legal in the current state. An illegal command is ignored and flagged with a one-cycle error pulse.

Transmit or receive is always entered through one of two timed waits. When calibration is enabled, a calibration wait of about 300 µs is used. Otherwise a short settling wait of about 35 µs is used. Once the wait ends, the selected path is switched on. Transmit and receive are never active together. When the transmit or receive path reports that its packet is finished, the controller drops back to light sleep by itself.

In periodic operation the controller parks in idle. A wake timer with a period of about 1 ms then drives it through light sleep, standby and the wait into the last direction that was commanded. After each packet it returns to idle. All wait lengths are computed from a clock-frequency parameter.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset the state output is deep sleep and every enable output, ready and the error pulse are low. The state codes are: deep sleep 0, idle 1, light sleep 2, standby 3, calibration 4, settling 5, transmit 6, receive 7.
- R2: In deep sleep or idle, a command with bit 2 set moves the controller to light sleep. In deep sleep, a command with bit 2 clear is illegal. Command 000 moves light sleep, standby or idle to deep sleep.
- R3: In light sleep, the commands map as follows: 100 selects standby, 101 selects receive, 111 selects transmit, and 110 enters idle with periodic operation armed. In standby, 101 and 111 select receive and transmit.
- R4: While the crystal-ready input is low, light sleep is never left, and any command given there is illegal.
- R5: With calibration disabled, selecting a direction enters settling. Settling lasts exactly SETTLE_CYC cycles, where SETTLE_CYC is the clock frequency times 35 µs. The synthesizer enable is high during settling, and the selected path follows.
- R6: With the calibration enable high when a direction is selected, the controller enters calibration instead. Calibration lasts exactly CAL_CYC cycles, where CAL_CYC is the clock frequency times 300 µs. The calibration busy output and the synthesizer enable are high during calibration.
- R7: The transmit enable is high only in transmit and the receive enable only in receive. The two are never high together.
- R8: A transmit-done pulse in transmit, or a receive-done pulse in receive, returns the controller to light sleep on the next cycle. A done pulse from the other path is ignored.
- R9: In periodic operation the controller leaves idle for light sleep once every WAKE_CYC cycles, counted from arming, where WAKE_CYC is the clock frequency times 1 ms. It then proceeds automatically on consecutive cycles to standby, to the wait, and to the last direction commanded (receive after reset). After the packet it returns to idle.
- R10: A command that is illegal in the current state leaves the state unchanged and raises the error output for exactly the cycle after the strobe. Every command is illegal in calibration, settling, transmit and receive.
- R11: The ready output is high exactly when the state is light sleep or standby and the crystal-ready input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| om_wr | input | 1 | Mode command strobe |
| om_val | input | 3 | Mode command value |
| cal_en | input | 1 | Use calibration instead of settling on direction entry |
| xtal_rdy | input | 1 | Crystal oscillator stable |
| tx_done | input | 1 | Transmit packet finished pulse |
| rx_done | input | 1 | Receive packet finished pulse |
| state_o | output | 3 | Current state code |
| synth_en | output | 1 | Synthesizer enable |
| cal_busy | output | 1 | Calibration running |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| ready | output | 1 | Able to accept a direction command |
| cmd_err | output | 1 | Illegal command pulse |

## Verification
The bench measures the settling and calibration windows to the exact cycle at both ends. A counter that is off by one would show the transmit or receive state one cycle early or late. It holds the crystal input low in light sleep and checks for a rejected command with an error pulse; a design that skipped this gate would move on to standby or a wait. It pulses the wrong-direction done input during transmit, which a design that merged the two done inputs would treat as an exit. It times the periodic wake to its exact cycle, and then checks that after the packet the controller returns to idle rather than light sleep.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

   typedef enum logic [2:0] {
      ST_DEEP   = 3'd0,
      ST_IDLE   = 3'd1,
      ST_LIGHT  = 3'd2,
      ST_STBY   = 3'd3,
      ST_CAL    = 3'd4,
      ST_SETTLE = 3'd5,
      ST_TX     = 3'd6,
      ST_RX     = 3'd7
   } rmc_state_t;

   localparam logic [2:0] CMD_DEEP  = 3'b000;
   localparam logic [2:0] CMD_STBY  = 3'b100;
   localparam logic [2:0] CMD_RX    = 3'b101;
   localparam logic [2:0] CMD_IDLE  = 3'b110;
   localparam logic [2:0] CMD_TX    = 3'b111;

   function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                longint unsigned ns);
      longint unsigned prod;
      prod = clk_hz * ns;
      return int'(prod / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/rmc_wait_timer.sv
module rmc_wait_timer #(
   parameter int unsigned SHORT_CYC = 35,
   parameter int unsigned LONG_CYC  = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sel_long,
   output logic done
);
   localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);
   localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
   localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= sel_long ? LONG_LD : SHORT_LD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/rmc_wake_timer.sv
module rmc_wake_timer #(
   parameter int unsigned PERIOD_CYC = 1000,
   parameter bit          ENABLE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   localparam int unsigned CW = $clog2(PERIOD_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

   generate
      if (ENABLE) begin : g_timer
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run)
               cnt <= '0;
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
         assign hit = run && (cnt == LAST);
      end else begin : g_none
         assign hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
   import rmc_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 125_000_000,
   parameter longint unsigned SETTLE_NS = 35_000,
   parameter longint unsigned CAL_NS    = 300_000,
   parameter longint unsigned WAKE_NS   = 1_000_000,
   parameter bit              PERIODIC  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       om_wr,
   input  logic [2:0] om_val,
   input  logic       cal_en,
   input  logic       xtal_rdy,
   input  logic       tx_done,
   input  logic       rx_done,
   output logic [2:0] state_o,
   output logic       synth_en,
   output logic       cal_busy,
   output logic       tx_en,
   output logic       rx_en,
   output logic       ready,
   output logic       cmd_err
);
   localparam int unsigned SETTLE_CYC = ns_to_cycles(CLK_HZ, SETTLE_NS);
   localparam int unsigned CAL_CYC    = ns_to_cycles(CLK_HZ, CAL_NS);
   localparam int unsigned WAKE_CYC   = ns_to_cycles(CLK_HZ, WAKE_NS);

   generate
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("settling window shorter than two cycles");
      end
      if (CAL_CYC < 2) begin : g_bad_cal
         $error("calibration window shorter than two cycles");
      end
      if (PERIODIC && WAKE_CYC < 16) begin : g_bad_wake
         $error("wake period too short");
      end
   endgenerate

   rmc_state_t st_q, st_d;
   logic       per_q, per_set, per_clr;
   logic       dir_q, dir_d;
   logic       accept, wt_load, wt_long, wt_done, wake_hit, err_q;

   rmc_wait_timer #(.SHORT_CYC(SETTLE_CYC), .LONG_CYC(CAL_CYC)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wt_load),
      .sel_long (wt_long),
      .done     (wt_done)
   );

   rmc_wake_timer #(.PERIOD_CYC(WAKE_CYC), .ENABLE(PERIODIC)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (per_q),
      .hit   (wake_hit)
   );

   always_comb begin
      st_d    = st_q;
      dir_d   = dir_q;
      accept  = 1'b0;
      wt_load = 1'b0;
      wt_long = cal_en;
      per_set = 1'b0;
      unique case (st_q)
         ST_DEEP: begin
            if (om_wr && om_val[2]) begin
               accept = 1'b1;
               st_d   = ST_LIGHT;
            end
         end
         ST_IDLE: begin
            if (om_wr) begin
               if (om_val == CMD_DEEP) begin
                  accept = 1'b1;
                  st_d   = ST_DEEP;
               end else if (om_val[2]) begin
                  accept = 1'b1;
                  st_d   = ST_LIGHT;
               end
            end else if (per_q && wake_hit) begin
               st_d = ST_LIGHT;
            end
         end
         ST_LIGHT: begin
            if (om_wr && xtal_rdy) begin
               unique case (om_val)
                  CMD_DEEP: begin accept = 1'b1; st_d = ST_DEEP; end
                  CMD_STBY: begin accept = 1'b1; st_d = ST_STBY; end
                  CMD_IDLE: begin
                     if (PERIODIC) begin
                        accept  = 1'b1;
                        per_set = 1'b1;
                        st_d    = ST_IDLE;
                     end
                  end
                  CMD_RX, CMD_TX: begin
                     accept  = 1'b1;
                     dir_d   = om_val[1];
                     wt_load = 1'b1;
                     st_d    = cal_en ? ST_CAL : ST_SETTLE;
                  end
                  default: ;
               endcase
            end else if (!om_wr && per_q && xtal_rdy) begin
               st_d = ST_STBY;
            end
         end
         ST_STBY: begin
            if (om_wr) begin
               if (om_val == CMD_DEEP) begin
                  accept = 1'b1;
                  st_d   = ST_DEEP;
               end else if (om_val == CMD_RX || om_val == CMD_TX) begin
                  accept  = 1'b1;
                  dir_d   = om_val[1];
                  wt_load = 1'b1;
                  st_d    = cal_en ? ST_CAL : ST_SETTLE;
               end
            end else if (per_q) begin
               wt_load = 1'b1;
               st_d    = cal_en ? ST_CAL : ST_SETTLE;
            end
         end
         ST_CAL, ST_SETTLE: begin
            if (wt_done)
               st_d = dir_q ? ST_TX : ST_RX;
         end
         ST_TX: begin
            if (tx_done)
               st_d = per_q ? ST_IDLE : ST_LIGHT;
         end
         ST_RX: begin
            if (rx_done)
               st_d = per_q ? ST_IDLE : ST_LIGHT;
         end
         default: st_d = ST_DEEP;
      endcase
   end

   assign per_clr = accept && !per_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_DEEP;
         per_q <= 1'b0;
         dir_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         dir_q <= dir_d;
         err_q <= om_wr && !accept;
         if (per_set)
            per_q <= 1'b1;
         else if (per_clr)
            per_q <= 1'b0;
      end
   end

   assign state_o  = st_q;
   assign synth_en = (st_q == ST_CAL) || (st_q == ST_SETTLE) ||
                     (st_q == ST_TX)  || (st_q == ST_RX);
   assign cal_busy = (st_q == ST_CAL);
   assign tx_en    = (st_q == ST_TX);
   assign rx_en    = (st_q == ST_RX);
   assign ready    = xtal_rdy && ((st_q == ST_LIGHT) || (st_q == ST_STBY));
   assign cmd_err  = err_q;

endmodule

// File: rtl/rmc_checker.sv
module rmc_checker #(
   parameter int unsigned SETTLE_CYC = 35
) (
   input logic       clk,
   input logic       rst_n,
   input logic       om_wr,
   input logic       xtal_rdy,
   input logic       tx_done,
   input logic [2:0] state_o,
   input logic       synth_en,
   input logic       cal_busy,
   input logic       tx_en,
   input logic       rx_en,
   input logic       cmd_err
);
   int unsigned settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         settle_cnt <= 0;
      else if (state_o == 3'd5)
         settle_cnt <= settle_cnt + 1;
      else
         settle_cnt <= 0;
   end

   AST_TXRX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en && rx_en)); // R7
   AST_ERR_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(om_wr)); // R10
   AST_TX_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> ($past(state_o) == 3'd5 || $past(state_o) == 3'd4)); // R5
   AST_CAL_SYNTH: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> synth_en); // R6
   AST_TX_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd6 && tx_done) |=> (state_o == 3'd2 || state_o == 3'd1)); // R8
   AST_XTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && !xtal_rdy) |=> state_o == 3'd2); // R4
   AST_DEEP_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && !om_wr) |=> state_o == 3'd0); // R2
   AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd5) |-> (settle_cnt < SETTLE_CYC)); // R5

endmodule

bind radio_mode_ctrl rmc_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .om_wr    (om_wr),
   .xtal_rdy (xtal_rdy),
   .tx_done  (tx_done),
   .state_o  (state_o),
   .synth_en (synth_en),
   .cal_busy (cal_busy),
   .tx_en    (tx_en),
   .rx_en    (rx_en),
   .cmd_err  (cmd_err)
);

// File: tb/sim_radio_mode_ctrl.sv
module sim_radio_mode_ctrl;
   localparam longint unsigned CLK_HZ = 1_000_000;
   localparam int N = int'((CLK_HZ * 64'd35_000) / 64'd1_000_000_000);
   localparam int C = int'((CLK_HZ * 64'd300_000) / 64'd1_000_000_000);
   localparam int W = int'((CLK_HZ * 64'd1_000_000) / 64'd1_000_000_000);

   logic clk = 1'b0, rst_n = 1'b0;
   logic om_wr = 1'b0, cal_en = 1'b0, xtal_rdy = 1'b1, tx_done = 1'b0, rx_done = 1'b0;
   logic [2:0] om_val = 3'd0;
   logic [2:0] state_o;
   logic synth_en, cal_busy, tx_en, rx_en, ready, cmd_err;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   radio_mode_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
      .clk(clk), .rst_n(rst_n), .om_wr(om_wr), .om_val(om_val), .cal_en(cal_en),
      .xtal_rdy(xtal_rdy), .tx_done(tx_done), .rx_done(rx_done), .state_o(state_o),
      .synth_en(synth_en), .cal_busy(cal_busy), .tx_en(tx_en), .rx_en(rx_en),
      .ready(ready), .cmd_err(cmd_err));

   // {req[3:0], cmd[2:0], xtal, expected state[2:0], expected err}
   localparam int NV = 16;
   localparam logic [11:0] VEC [NV] = '{
      {4'd2,  3'b000, 1'b1, 3'd0, 1'b1},  // R2 low-bit command in deep sleep illegal
      {4'd2,  3'b100, 1'b1, 3'd2, 1'b0},  // R2 deep -> light
      {4'd4,  3'b101, 1'b0, 3'd2, 1'b1},  // R4 crystal low blocks
      {4'd3,  3'b100, 1'b1, 3'd3, 1'b0},  // R3 light -> standby
      {4'd10, 3'b110, 1'b1, 3'd3, 1'b1},  // R10 idle command illegal in standby
      {4'd2,  3'b000, 1'b1, 3'd0, 1'b0},  // R2 standby -> deep
      {4'd2,  3'b101, 1'b1, 3'd2, 1'b0},  // R2 any bit-2 command wakes deep
      {4'd10, 3'b010, 1'b1, 3'd2, 1'b1},  // R10 undefined command in light
      {4'd2,  3'b000, 1'b1, 3'd0, 1'b0},  // R2 light -> deep
      {4'd2,  3'b111, 1'b1, 3'd2, 1'b0},  // R2 deep -> light
      {4'd3,  3'b110, 1'b1, 3'd1, 1'b0},  // R3 light -> idle
      {4'd2,  3'b100, 1'b1, 3'd2, 1'b0},  // R2 idle -> light
      {4'd3,  3'b110, 1'b1, 3'd1, 1'b0},  // R3 light -> idle
      {4'd10, 3'b011, 1'b1, 3'd1, 1'b1},  // R10 illegal in idle
      {4'd2,  3'b000, 1'b1, 3'd0, 1'b0},  // R2 idle -> deep
      {4'd2,  3'b100, 1'b1, 3'd2, 1'b0}   // R2 deep -> light
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] v);
      @(negedge clk);
      om_wr = 1'b1; om_val = v;
      @(negedge clk);
      om_wr = 1'b0;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 150_000);
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      cycles(3);
      // R1 reset state
      chk(state_o == 3'd0, "R1 state", state_o, 0);
      chk({synth_en, cal_busy, tx_en, rx_en, ready, cmd_err} == 6'b0, "R1 outputs",
          {synth_en, cal_busy, tx_en, rx_en, ready, cmd_err}, 0);
      @(negedge clk) rst_n = 1'b1;
      cycles(2);
      chk(state_o == 3'd0, "R1 state after release", state_o, 0);

      for (int i = 0; i < NV; i++) begin
         xtal_rdy = VEC[i][4];
         cmd(VEC[i][7:5]);
         chk(state_o == VEC[i][3:1], $sformatf("R%0d vector %0d state", VEC[i][11:8], i),
             state_o, VEC[i][3:1]);
         chk(cmd_err == VEC[i][0], $sformatf("R%0d vector %0d err", VEC[i][11:8], i),
             cmd_err, VEC[i][0]);
      end
      xtal_rdy = 1'b1;
      @(negedge clk);
      chk(cmd_err == 1'b0, "R10 err single cycle", cmd_err, 0);

      // R11 ready follows crystal in light sleep
      chk(ready == 1'b1, "R11 ready light", ready, 1);
      xtal_rdy = 1'b0; #1;
      chk(ready == 1'b0, "R11 ready crystal low", ready, 0);
      xtal_rdy = 1'b1;

      // R5 settling into transmit
      cal_en = 1'b0;
      cmd(3'b111);
      chk(state_o == 3'd5 && synth_en && !tx_en, "R5 settling entry", state_o, 5);
      chk(ready == 1'b0, "R11 not ready in settling", ready, 0);
      cycles(N - 1);
      chk(state_o == 3'd5, "R5 settling last cycle", state_o, 5);
      cycles(1);
      chk(state_o == 3'd6, "R5 transmit after settle", state_o, 6);
      chk(tx_en && !rx_en, "R7 tx only", {tx_en, rx_en}, 2);
      cmd(3'b100);
      chk(state_o == 3'd6 && cmd_err, "R10 command in transmit", {state_o, cmd_err}, 13);
      @(negedge clk) rx_done = 1'b1;
      @(negedge clk) rx_done = 1'b0;
      chk(state_o == 3'd6, "R8 rx_done ignored in transmit", state_o, 6);
      @(negedge clk) tx_done = 1'b1;
      @(negedge clk) tx_done = 1'b0;
      chk(state_o == 3'd2, "R8 transmit done to light", state_o, 2);

      // R6 calibration into receive
      cal_en = 1'b1;
      cmd(3'b101);
      chk(state_o == 3'd4 && cal_busy && synth_en, "R6 calibration entry", state_o, 4);
      cycles(C - 1);
      chk(state_o == 3'd4, "R6 calibration last cycle", state_o, 4);
      cycles(1);
      chk(state_o == 3'd7 && rx_en && !tx_en && !cal_busy, "R6 receive after cal", state_o, 7);
      @(negedge clk) rx_done = 1'b1;
      @(negedge clk) rx_done = 1'b0;
      chk(state_o == 3'd2, "R8 receive done to light", state_o, 2);

      // R3 standby then direction
      cal_en = 1'b0;
      cmd(3'b100);
      chk(state_o == 3'd3 && ready, "R3 standby", state_o, 3);
      cmd(3'b101);
      chk(state_o == 3'd5, "R3 standby direction", state_o, 5);
      cycles(N);
      chk(state_o == 3'd7, "R3 receive from standby", state_o, 7);
      @(negedge clk) rx_done = 1'b1;
      @(negedge clk) rx_done = 1'b0;

      // R9 periodic wake, last direction receive
      cmd(3'b110);
      chk(state_o == 3'd1, "R9 idle armed", state_o, 1);
      cycles(W - 1);
      chk(state_o == 3'd1, "R9 idle before expiry", state_o, 1);
      cycles(1);
      chk(state_o == 3'd2, "R9 wake to light", state_o, 2);
      cycles(1);
      chk(state_o == 3'd3, "R9 auto standby", state_o, 3);
      cycles(1);
      chk(state_o == 3'd5, "R9 auto settle", state_o, 5);
      cycles(N);
      chk(state_o == 3'd7, "R9 receive", state_o, 7);
      @(negedge clk) rx_done = 1'b1;
      @(negedge clk) rx_done = 1'b0;
      chk(state_o == 3'd1, "R9 back to idle", state_o, 1);
      cmd(3'b000);
      chk(state_o == 3'd0 && !cmd_err, "R2 idle to deep", state_o, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule